// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the system clock. An 8-bit prescale field, held steady by a configuration register elsewhere, selects the division ratio. The block produces the SCK level, plus two single-cycle strobes that tell the shift engine when the leading edge and the trailing edge of each SCK period occur. A build-time parameter picks how the field is read. The first reading is a multiplier-times-power-of-two encoding, whose exponent bits are not contiguous in the field. The second is a compact legacy encoding that only gives even dividers.

The behaviour is set by a three-state phase machine. PH_IDLE holds SCK at the CPOL level. PH_LEAD holds SCK at the level opposite to CPOL. PH_TRAIL holds SCK back at the CPOL level. The transitions are as follows:
- START: PH_IDLE to PH_LEAD when run is high and the field is unchanged.
- FLIP: PH_LEAD to PH_TRAIL when the leading half has run out.
- WRAP: PH_TRAIL to PH_LEAD when the trailing half has run out.
- HALT: PH_LEAD or PH_TRAIL to PH_IDLE when run is low or the field has changed since the previous cycle.

A down-counter, reloaded on each START, FLIP and WRAP, times each half.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With EXP_MODE=1 the divider N equals M × 2^E. M is field[3:0]. E is the 3-bit value {field[7], field[6], field[4]}. Field bit 5 has no effect on N.
- R2: With EXP_MODE=0 only field[4:0] matters. A value 0x10+k with k from 2 to 15 gives N = 2k, so N runs over the even values 4 to 30. Bits 7:5 have no effect.
- R3: Any decoded divider below 4 becomes 4. This covers a legacy field[4:0] below 0x12, an exponent-mode M of 0, and any product below 4. N never exceeds 1920.
- R4: While running, the SCK period is N system cycles. SCK stays away from its idle level for floor(N/2) cycles and at its idle level for ceil(N/2) cycles.
- R5: lead_stb is high for exactly one cycle, in the first cycle that SCK is away from the CPOL level. trail_stb is high for exactly one cycle, in the first cycle that SCK is back at the CPOL level.
- R6: While the machine is idle, SCK equals cpol. After run is sampled low, SCK is at the CPOL level from the next cycle on, and no strobe is raised.
- R7: When run is first sampled high with a stable field, the leading edge and lead_stb appear in the following cycle.
- R8: A change of the prescale field while running forces one idle cycle. The next period then restarts with a leading edge and uses the new divider.
- R9: During and right after reset, SCK equals cpol and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale_fld | input | 8 | Prescale field from the configuration register |
| run | input | 1 | High to generate SCK, low to hold it idle |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe on each leading edge |
| trail_stb | output | 1 | One-cycle strobe on each trailing edge |

## Verification
The bench builds two copies of the block and drives both from the same stimulus. One copy has EXP_MODE=1 and the other has EXP_MODE=0. Both copies see every one of the 256 field values, so every decoder path is measured: the full exponent range up to the 1920 divider, the odd dividers with their uneven halves, field bit 5 and the upper legacy bits being ignored, and each clamp to 4. Directed sequences on the exponent copy check the exact start, stop and restart cycles, and the idle level with both CPOL settings.

// File: rtl/spk_pkg.sv
package spk_pkg;

    // Width of the decoded divider: 15 << 7 = 1920 needs 11 bits
    localparam int DIV_W   = 11;
    localparam int FLD_W   = 8;
    localparam int MIN_DIV = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRAIL = 2'd2
    } phase_e;

endpackage

// File: rtl/spk_ratio_decode.sv
module spk_ratio_decode
    import spk_pkg::*;
#(
    parameter bit EXP_MODE = 1'b1
) (
    input  logic [FLD_W-1:0] fld,
    output logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] half_lead,
    output logic [DIV_W-1:0] half_trail
);

    localparam int MANT_W = 4;
    localparam int EXPN_W = 3;
    localparam int LEG_W  = 5;
    localparam logic [LEG_W-1:0] LEG_FLOOR = LEG_W'(5'h12);

    logic [DIV_W-1:0] raw;

    generate
        if (EXP_MODE) begin : g_exp
            logic [MANT_W-1:0] mant;
            logic [EXPN_W-1:0] expn;
            always_comb begin
                mant = fld[3:0];
                // exponent bit 0 lives apart from bits 2:1; field bit 5 is skipped
                expn = {fld[7], fld[6], fld[4]};
                raw  = DIV_W'(mant) << expn;
            end
        end else begin : g_leg
            logic [LEG_W-1:0] low;
            always_comb begin
                low = fld[LEG_W-1:0];
                if (low < LEG_FLOOR)
                    raw = '0;
                else
                    raw = DIV_W'({low[3:0], 1'b0});
            end
        end
    endgenerate

    always_comb begin
        if (raw < DIV_W'(MIN_DIV))
            div = DIV_W'(MIN_DIV);
        else
            div = raw;
        half_lead  = div >> 1;
        half_trail = div - half_lead;
    end

endmodule

// File: rtl/spk_field_watch.sv
module spk_field_watch
    import spk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] fld,
    output logic             changed
);

    logic [FLD_W-1:0] fld_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            fld_q <= '0;
        else
            fld_q <= fld;
    end

    assign changed = (fld != fld_q);

endmodule

// File: rtl/spk_phase_fsm.sv
module spk_phase_fsm
    import spk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             cpol,
    input  logic [DIV_W-1:0] half_lead,
    input  logic [DIV_W-1:0] half_trail,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);

    phase_e           state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             fresh_q, fresh_d;
    logic             halt;

    assign halt = !run || restart;

    // next-state and counter reload
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fresh_d = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (!halt) begin
                    state_d = PH_LEAD;
                    cnt_d   = half_lead - DIV_W'(1);
                    fresh_d = 1'b1;
                end
            end
            PH_LEAD: begin
                if (halt) begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = PH_TRAIL;
                    cnt_d   = half_trail - DIV_W'(1);
                    fresh_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            PH_TRAIL: begin
                if (halt) begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = PH_LEAD;
                    cnt_d   = half_lead - DIV_W'(1);
                    fresh_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            fresh_q <= fresh_d;
        end
    end

    // outputs
    always_comb begin
        sck       = cpol;
        lead_stb  = 1'b0;
        trail_stb = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_LEAD: begin
                sck      = !cpol;
                lead_stb = fresh_q;
            end
            PH_TRAIL: begin
                trail_stb = fresh_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spk_pkg::*;
#(
    parameter bit EXP_MODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] prescale_fld,
    input  logic             run,
    input  logic             cpol,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);

    logic [DIV_W-1:0] div_w;
    logic [DIV_W-1:0] hi_w;
    logic [DIV_W-1:0] lo_w;
    logic             chg_w;

    spk_ratio_decode #(
        .EXP_MODE (EXP_MODE)
    ) u_dec (
        .fld        (prescale_fld),
        .div        (div_w),
        .half_lead  (hi_w),
        .half_trail (lo_w)
    );

    spk_field_watch u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fld     (prescale_fld),
        .changed (chg_w)
    );

    spk_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (chg_w),
        .cpol       (cpol),
        .half_lead  (hi_w),
        .half_trail (lo_w),
        .sck        (sck),
        .lead_stb   (lead_stb),
        .trail_stb  (trail_stb)
    );

endmodule

// File: rtl/spk_checker.sv
module spk_checker
    import spk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cpol,
    input logic             sck,
    input logic             lead_stb,
    input logic             trail_stb,
    input logic [DIV_W-1:0] div,
    input logic [DIV_W-1:0] half_lead
);

    logic [DIV_W-1:0] since_lead;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_lead <= '0;
        else if (lead_stb)
            since_lead <= DIV_W'(1);
        else if (since_lead != '1)
            since_lead <= since_lead + DIV_W'(1);
    end

    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        (div >= DIV_W'(MIN_DIV)) && (div <= DIV_W'(1920)));

    a_r4_lead_len: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (since_lead == half_lead));

    a_r5_lead_single: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> !lead_stb);

    a_r5_trail_single: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |=> !trail_stb);

    a_r5_lead_level: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sck != cpol));

    a_r5_trail_level: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sck == cpol));

    a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((sck == cpol) && !lead_stb && !trail_stb));

endmodule

bind spi_sck_prescaler spk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cpol),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .div       (div_w),
    .half_lead (hi_w)
);

// File: tb/sim_spi_sck_prescaler.sv
module sim_spi_sck_prescaler;

    typedef struct {
        int per;
        int hi;
        int fld;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fld = 8'h00;
    logic       run = 1'b0;
    logic       cpol = 1'b0;
    logic       sck0, lead0, trail0;
    logic       sck1, lead1, trail1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    exp_t q0[$];
    exp_t q1[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sck_prescaler #(.EXP_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .prescale_fld(fld), .run(run), .cpol(cpol),
        .sck(sck0), .lead_stb(lead0), .trail_stb(trail0)
    );

    spi_sck_prescaler #(.EXP_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .prescale_fld(fld), .run(run), .cpol(cpol),
        .sck(sck1), .lead_stb(lead1), .trail_stb(trail1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // expected divider, from R1, R2 and R3
    function automatic int model_div(input logic [7:0] f, input bit expm);
        int n;
        int low;
        if (expm) begin
            n = int'(f[3:0]) * (1 << int'({f[7], f[6], f[4]}));
        end else begin
            low = int'(f[4:0]);
            n = (low < 18) ? 0 : 2 * (low - 16);
        end
        if (n < 4) n = 4;
        return n;
    endfunction

    // monitor for the exponent copy
    int  tl0 = 0, tt0 = 0;
    bit  hl0 = 1'b0;
    always @(negedge clk) begin
        if (!run) hl0 = 1'b0;
        else begin
            if (trail0) tt0 = cyc;
            if (lead0) begin
                if (hl0 && q0.size() > 0) begin
                    exp_t e;
                    e = q0.pop_front();
                    chk((cyc - tl0) == e.per, $sformatf("R1/R3/R4 exp period fld=%0h", e.fld), cyc - tl0, e.per);
                    chk((tt0 - tl0) == e.hi, $sformatf("R4 exp lead half fld=%0h", e.fld), tt0 - tl0, e.hi);
                end
                tl0 = cyc;
                hl0 = 1'b1;
            end
        end
    end

    // monitor for the legacy copy
    int  tl1 = 0, tt1 = 0;
    bit  hl1 = 1'b0;
    always @(negedge clk) begin
        if (!run) hl1 = 1'b0;
        else begin
            if (trail1) tt1 = cyc;
            if (lead1) begin
                if (hl1 && q1.size() > 0) begin
                    exp_t e;
                    e = q1.pop_front();
                    chk((cyc - tl1) == e.per, $sformatf("R2/R3/R4 legacy period fld=%0h", e.fld), cyc - tl1, e.per);
                    chk((tt1 - tl1) == e.hi, $sformatf("R4 legacy lead half fld=%0h", e.fld), tt1 - tl1, e.hi);
                end
                tl1 = cyc;
                hl1 = 1'b1;
            end
        end
    end

    // driver: one measured period per field value on both copies
    task automatic sweep_field(input logic [7:0] f);
        exp_t e0, e1;
        @(posedge clk); #1;
        run = 1'b0;
        fld = f;
        repeat (3) @(posedge clk);
        e0.per = model_div(f, 1'b1); e0.hi = e0.per / 2; e0.fld = int'(f);
        e1.per = model_div(f, 1'b0); e1.hi = e1.per / 2; e1.fld = int'(f);
        q0.push_back(e0);
        q1.push_back(e1);
        #1 run = 1'b1;
        while (q0.size() > 0 || q1.size() > 0) @(posedge clk);
        #1 run = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        // R9: reset state
        repeat (2) @(negedge clk);
        chk(sck0 == 1'b0 && !lead0 && !trail0, "R9 reset state", int'(sck0), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sck0 == 1'b0 && !lead0 && !trail0, "R9 after reset", int'(sck0), 0);

        // R7: start latency, divider 8
        @(posedge clk); #1 fld = 8'h08;
        repeat (3) @(posedge clk);
        #1 run = 1'b1;
        @(negedge clk);
        chk(sck0 == 1'b0 && !lead0, "R7 no edge before sampling", int'(sck0), 0);
        @(negedge clk);
        chk(sck0 == 1'b1 && lead0, "R7 leading edge next cycle", int'(lead0), 1);

        // R8: field change while running
        @(posedge clk); #1 fld = 8'h04;
        @(negedge clk);
        @(negedge clk);
        chk(sck0 == 1'b0 && !lead0 && !trail0, "R8 idle after change", int'(sck0), 0);
        @(negedge clk);
        chk(sck0 == 1'b1 && lead0, "R8 restart edge", int'(lead0), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!lead0 && n < 100);
        chk(n == 4, "R8 new divider period", n, 4);

        // R6: stop returns to idle without strobes
        @(posedge clk); #1 run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sck0 == 1'b0 && !lead0 && !trail0, "R6 idle after stop", int'(sck0), 0);

        // R6/R7 with CPOL=1
        @(posedge clk); #1 cpol = 1'b1;
        @(negedge clk);
        chk(sck0 == 1'b1, "R6 idle level follows cpol", int'(sck0), 1);
        @(posedge clk); #1 run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sck0 == 1'b0 && lead0, "R7 leading edge with cpol=1", int'(sck0), 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!trail0 && n < 100);
        chk(n == 2 && sck0 == 1'b1, "R4/R5 trailing edge with cpol=1", n, 2);
        @(negedge clk);
        chk(!trail0, "R5 trail strobe one cycle", int'(trail0), 0);
        @(posedge clk); #1 run = 1'b0; cpol = 1'b0;
        repeat (2) @(posedge clk);

        // R1..R4: every field value on both encodings
        for (int f = 0; f < 256; f++) sweep_field(8'(f));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule